// File: doc/BRIEF.md
# RDS Block Status and Interrupt Registers

This unit sits between a serial register port and an RDS block decoder. Every time the decoder finishes a block it pulses an event that carries several fields: the block number, a paging-block (E) flag, a syndrome-zero flag, and the TA and TA-EON traffic indications. Before that event arrives, the demodulator streams one bad/good quality mark for each received bit. The unit counts the bad marks of the current block and saturates the count. It captures the block status into a read-only quality register when the event arrives. It also raises a sticky interrupt when the event matches the selected interrupt source.

Software reaches the unit through already-deserialised byte writes and read strobes. A write to the control register or the block-control register only takes effect when bit 7 of the shifted-in byte is 1. Writing the resync bit, or changing the interrupt source, sends a one-cycle resynchronisation pulse to the decoder. Reading the control register clears the interrupt flag and the block-detected flag.

Top module: `rds_stat_regs`

## Requirements
- R1: After reset every register field, `rd_data_o` for addresses 0 to 2, `irq_o`, `resync_o` and `blk_ctrl_o` are zero.
- R2: A write to address 0 (control) or address 2 (block control) is applied only when `wr_data_i[7]` is 1. Otherwise it is discarded and leaves the register unchanged.
- R3: Reading address 0 returns this layout: bit 7 write-enable (the value last accepted), bit 6 block-detected, bit 5 resync (always reads 0), bit 4 synchronised, bits 3:1 interrupt source, bit 0 interrupt flag.
- R4: Interrupt source codes are 000 none, 001 any block, 010 block A, 011 block B, 110 block D, 111 TA set, 101 TA-EON set. A block-number match also needs the E flag to be 0. Code 100 never interrupts.
- R5: An event that matches the source sets the interrupt flag at the clock edge where the event is sampled. The flag stays set until it is cleared, and `irq_o` mirrors it.
- R6: A read strobe on address 0 clears the interrupt flag and the block-detected flag at that edge. If a matching event arrives in the same cycle, the set wins.
- R7: An accepted control write pulses `resync_o` high for exactly the next cycle when data bit 5 is 1 or bits 3:1 differ from the stored source. Otherwise no pulse is sent.
- R8: The bad-bit count adds one for each `qbit_valid_i` with `qbit_bad_i` high, saturates at 15, and restarts at zero after each event.
- R9: Reading address 1 returns this layout: bit 7 syndrome-zero, bit 6 E flag, bits 5:2 bad-bit count, bits 1:0 block number (A=00, B=01, C/C'=10, D=11). All of it is captured at the event edge and held between events.
- R10: Control bit 4 follows `synced_i` directly.
- R11: Every event sets the block-detected bit, whatever the source selection.
- R12: `blk_ctrl_o` holds the last accepted write to address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Deserialised write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 8 | Write data byte |
| rd_strobe_i | input | 1 | Read strobe (clears on address 0) |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 8 | Read data, combinational |
| evt_valid_i | input | 1 | Decoder block-done event |
| evt_blk_i | input | 2 | Block number of the event |
| evt_e_blk_i | input | 1 | Paging block E flag |
| evt_synz_i | input | 1 | Syndrome zero after correction |
| evt_ta_i | input | 1 | TA indication |
| evt_taeon_i | input | 1 | TA-EON indication |
| qbit_valid_i | input | 1 | One received bit's quality mark valid |
| qbit_bad_i | input | 1 | Quality mark: bit flagged bad |
| synced_i | input | 1 | Decoder locked |
| resync_o | output | 1 | One-cycle resynchronisation request |
| irq_o | output | 1 | Sticky interrupt flag |
| blk_ctrl_o | output | 8 | Block-control register |

## Verification
Writes, events and clearing reads all take effect at the one clock edge where they are sampled. So the interrupt flag, the quality register, `blk_ctrl_o` and the start of the resync pulse can be seen at the falling edge right after that edge, and the resync pulse is gone one cycle later. Read data is combinational. The scoreboard monitor samples it one nanosecond after the falling edge at which the driver raised the strobe. That is before the rising edge that applies the read-clear, so the check sees the value from before the clear. In the same-cycle collision case the expected read value shows the flag still clear, and `irq_o` is checked set at the next falling edge.

// File: rtl/rds_stat_pkg.sv
`timescale 1ns/1ps
package rds_stat_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int QCNT_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_QUAL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_BCTL = 2'd2;

  // control byte bit positions
  localparam int CB_WE   = 7;
  localparam int CB_BNE  = 6;
  localparam int CB_RSY  = 5;
  localparam int CB_SYN  = 4;
  localparam int CB_SRCL = 1;
  localparam int CB_INT  = 0;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'b000,
    SRC_ANY   = 3'b001,
    SRC_BLK_A = 3'b010,
    SRC_BLK_B = 3'b011,
    SRC_TAEON = 3'b101,
    SRC_BLK_D = 3'b110,
    SRC_TA    = 3'b111
  } irq_src_e;

  typedef enum logic [1:0] {
    BLK_A = 2'b00,
    BLK_B = 2'b01,
    BLK_C = 2'b10,
    BLK_D = 2'b11
  } blk_num_e;

  typedef struct packed {
    logic [1:0] blk;
    logic       e_blk;
    logic       synz;
    logic       ta;
    logic       taeon;
  } blk_evt_t;

  typedef struct packed {
    logic              synz;
    logic              e_blk;
    logic [QCNT_W-1:0] qcnt;
    logic [1:0]        blk;
  } qual_reg_t;
endpackage

// File: rtl/rds_qual_cnt.sv
`timescale 1ns/1ps
module rds_qual_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_bad_i,
  input  logic             blk_done_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  // a mark arriving with the event still belongs to the finished block
  always_comb begin
    cnt_nxt_o = cnt_q;
    if (bit_vld_i && bit_bad_i && (cnt_q != CNT_MAX)) cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (blk_done_i) cnt_q <= '0;
    else                 cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/rds_irq_match.sv
`timescale 1ns/1ps
module rds_irq_match
  import rds_stat_pkg::*;
(
  input  logic [2:0] src_i,
  input  logic       evt_vld_i,
  input  blk_evt_t   evt_i,
  output logic       hit_o
);
  logic is_blk;

  assign is_blk = !evt_i.e_blk;

  always_comb begin
    hit_o = 1'b0;
    if (evt_vld_i) begin
      case (src_i)
        SRC_ANY:   hit_o = 1'b1;
        SRC_BLK_A: hit_o = is_blk && (evt_i.blk == BLK_A);
        SRC_BLK_B: hit_o = is_blk && (evt_i.blk == BLK_B);
        SRC_BLK_D: hit_o = is_blk && (evt_i.blk == BLK_D);
        SRC_TA:    hit_o = evt_i.ta;
        SRC_TAEON: hit_o = evt_i.taeon;
        default:   hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rds_ctrl_reg.sv
`timescale 1ns/1ps
module rds_ctrl_reg
  import rds_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_acc_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_clr_i,
  input  logic             evt_vld_i,
  input  logic             hit_i,
  input  logic             synced_i,
  output logic [2:0]       src_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic             int_o,
  output logic             resync_o
);
  logic       we_q, bne_q, int_q, rsy_q;
  logic [2:0] src_q;
  logic [2:0] src_wr;
  logic       src_chg;
  logic       unused_wr;

  assign src_wr    = wr_data_i[CB_SRCL +: 3];
  assign src_chg   = (src_wr != src_q);
  assign unused_wr = ^{wr_data_i[CB_BNE], wr_data_i[CB_SYN], wr_data_i[CB_INT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q  <= 1'b0;
      src_q <= 3'b000;
      rsy_q <= 1'b0;
    end else begin
      rsy_q <= wr_acc_i && (wr_data_i[CB_RSY] || src_chg);
      if (wr_acc_i) begin
        we_q  <= wr_data_i[CB_WE];
        src_q <= src_wr;
      end
    end
  end

  // set beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      bne_q <= 1'b0;
    end else begin
      if (hit_i)         int_q <= 1'b1;
      else if (rd_clr_i) int_q <= 1'b0;
      if (evt_vld_i)     bne_q <= 1'b1;
      else if (rd_clr_i) bne_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o                  = '0;
    ctrl_o[CB_WE]           = we_q;
    ctrl_o[CB_BNE]          = bne_q;
    ctrl_o[CB_SYN]          = synced_i;
    ctrl_o[CB_SRCL +: 3]    = src_q;
    ctrl_o[CB_INT]          = int_q;
  end

  assign src_o    = src_q;
  assign int_o    = int_q;
  assign resync_o = rsy_q;
endmodule

// File: rtl/rds_stat_regs.sv
`timescale 1ns/1ps
module rds_stat_regs
  import rds_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_strobe_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              evt_valid_i,
  input  logic [1:0]        evt_blk_i,
  input  logic              evt_e_blk_i,
  input  logic              evt_synz_i,
  input  logic              evt_ta_i,
  input  logic              evt_taeon_i,
  input  logic              qbit_valid_i,
  input  logic              qbit_bad_i,
  input  logic              synced_i,
  output logic              resync_o,
  output logic              irq_o,
  output logic [REG_W-1:0]  blk_ctrl_o
);
  blk_evt_t          evt;
  logic              wr_ctrl, wr_bctl, rd_clr, hit;
  logic [2:0]        src;
  logic [REG_W-1:0]  ctrl_byte;
  logic [QCNT_W-1:0] qcnt_nxt;
  qual_reg_t         qual_q;
  logic [REG_W-1:0]  bctl_q;

  assign evt     = '{blk: evt_blk_i, e_blk: evt_e_blk_i, synz: evt_synz_i,
                     ta: evt_ta_i, taeon: evt_taeon_i};
  assign wr_ctrl = wr_valid_i && (wr_addr_i == ADDR_CTRL) && wr_data_i[CB_WE];
  assign wr_bctl = wr_valid_i && (wr_addr_i == ADDR_BCTL) && wr_data_i[CB_WE];
  assign rd_clr  = rd_strobe_i && (rd_addr_i == ADDR_CTRL);

  rds_qual_cnt #(.CNT_W(QCNT_W)) u_qcnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_vld_i  (qbit_valid_i),
    .bit_bad_i  (qbit_bad_i),
    .blk_done_i (evt_valid_i),
    .cnt_nxt_o  (qcnt_nxt)
  );

  rds_irq_match u_match (
    .src_i     (src),
    .evt_vld_i (evt_valid_i),
    .evt_i     (evt),
    .hit_o     (hit)
  );

  rds_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_acc_i  (wr_ctrl),
    .wr_data_i (wr_data_i),
    .rd_clr_i  (rd_clr),
    .evt_vld_i (evt_valid_i),
    .hit_i     (hit),
    .synced_i  (synced_i),
    .src_o     (src),
    .ctrl_o    (ctrl_byte),
    .int_o     (irq_o),
    .resync_o  (resync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) qual_q <= '0;
    else if (evt_valid_i)
      qual_q <= '{synz: evt.synz, e_blk: evt.e_blk, qcnt: qcnt_nxt, blk: evt.blk};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bctl_q <= '0;
    else if (wr_bctl) bctl_q <= wr_data_i;
  end

  always_comb begin
    case (rd_addr_i)
      ADDR_CTRL: rd_data_o = ctrl_byte;
      ADDR_QUAL: rd_data_o = qual_q;
      ADDR_BCTL: rd_data_o = bctl_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign blk_ctrl_o = bctl_q;
endmodule

// File: rtl/rds_stat_chk.sv
`timescale 1ns/1ps
module rds_stat_chk
  import rds_stat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic              rd_strobe_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              evt_valid_i,
  input logic              resync_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  blk_ctrl_o,
  input logic [REG_W-1:0]  qual_i
);
  assert_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(evt_valid_i));

  assert_irq_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(rd_strobe_i && rd_addr_i == ADDR_CTRL)) |=> irq_o);

  assert_rd_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_strobe_i && rd_addr_i == ADDR_CTRL && !evt_valid_i) |=> !irq_o);

  assert_resync_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> $past(wr_valid_i && wr_addr_i == ADDR_CTRL && wr_data_i[CB_WE]));

  assert_bctl_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_data_i[CB_WE]) |=> $stable(blk_ctrl_o));

  assert_qual_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_valid_i |=> $stable(qual_i));
endmodule

bind rds_stat_regs rds_stat_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_i  (wr_valid_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .rd_strobe_i (rd_strobe_i),
  .rd_addr_i   (rd_addr_i),
  .evt_valid_i (evt_valid_i),
  .resync_o    (resync_o),
  .irq_o       (irq_o),
  .blk_ctrl_o  (blk_ctrl_o),
  .qual_i      (qual_q)
);

// File: tb/rds_stat_regs_tb.sv
`timescale 1ns/1ps
module rds_stat_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_strobe = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       evt_valid = 1'b0;
  logic [1:0] evt_blk = '0;
  logic       evt_e = 1'b0, evt_synz = 1'b0, evt_ta = 1'b0, evt_taeon = 1'b0;
  logic       qbit_valid = 1'b0, qbit_bad = 1'b0;
  logic       synced = 1'b0;
  logic       resync, irq;
  logic [7:0] blk_ctrl;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  rds_stat_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_strobe_i(rd_strobe), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .evt_valid_i(evt_valid), .evt_blk_i(evt_blk), .evt_e_blk_i(evt_e),
    .evt_synz_i(evt_synz), .evt_ta_i(evt_ta), .evt_taeon_i(evt_taeon),
    .qbit_valid_i(qbit_valid), .qbit_bad_i(qbit_bad), .synced_i(synced),
    .resync_o(resync), .irq_o(irq), .blk_ctrl_o(blk_ctrl)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data while a strobe is up
  always @(negedge clk) begin
    #1;
    if (rd_strobe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=%02h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_strobe = 1'b1; rd_addr = a;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic evt(input logic [1:0] b, input logic e, input logic sz,
                     input logic ta, input logic te, input int nbad);
    for (int i = 0; i < nbad; i++) begin
      @(negedge clk); qbit_valid = 1'b1; qbit_bad = 1'b1;
    end
    @(negedge clk); qbit_valid = 1'b0; qbit_bad = 1'b0;
    @(negedge clk);
    evt_valid = 1'b1; evt_blk = b; evt_e = e; evt_synz = sz; evt_ta = ta; evt_taeon = te;
    @(negedge clk); evt_valid = 1'b0; evt_ta = 1'b0; evt_taeon = 1'b0;
  endtask

  task automatic chk_pulse(input string tag, input logic exp);
    chk(tag, {7'd0, resync}, {7'd0, exp});
    @(negedge clk);
    chk({tag, " tail"}, {7'd0, resync}, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 resync", {7'd0, resync}, 8'h00);
    chk("R1 blk_ctrl", blk_ctrl, 8'h00);
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 qual");
    rd(2'd2, 8'h00, "R1 bctl");

    // R2 gated writes
    wr(2'd0, 8'h22);
    chk_pulse("R2 no resync", 1'b0);
    rd(2'd0, 8'h00, "R2 ctrl discarded");
    wr(2'd2, 8'h15);
    chk("R2 bctl discarded", blk_ctrl, 8'h00);
    wr(2'd2, 8'h95);
    chk("R12 bctl", blk_ctrl, 8'h95);
    rd(2'd2, 8'h95, "R12 bctl read");

    // R7 source change, R3 layout
    wr(2'd0, 8'h82);
    chk_pulse("R7 src change", 1'b1);
    rd(2'd0, 8'h82, "R3 ctrl");
    synced = 1'b1;
    rd(2'd0, 8'h92, "R10 synced");
    synced = 1'b0;

    // R5/R8/R9/R11/R6
    evt(2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 3);
    chk("R5 irq any", {7'd0, irq}, 8'h01);
    rd(2'd1, 8'h8D, "R9 qual B");
    rd(2'd0, 8'hC3, "R11 ctrl");
    rd(2'd0, 8'h82, "R6 cleared");
    chk("R6 irq low", {7'd0, irq}, 8'h00);

    evt(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 20);
    rd(2'd1, 8'h3F, "R8 saturate");
    rd(2'd0, 8'hC3, "R5 sticky");
    evt(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    rd(2'd1, 8'h80, "R8 restart");
    rd(2'd0, 8'hC3, "R5 set A");

    // R4 block A
    wr(2'd0, 8'h84);
    chk_pulse("R7 src A", 1'b1);
    evt(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 A ignores B", {7'd0, irq}, 8'h00);
    evt(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 A hit", {7'd0, irq}, 8'h01);
    rd(2'd0, 8'hC5, "R4 ctrl A");

    // R4 block D and E flag
    wr(2'd0, 8'h8C);
    evt(2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 D ignores E", {7'd0, irq}, 8'h00);
    rd(2'd1, 8'h43, "R9 E flag");
    evt(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk("R4 D hit", {7'd0, irq}, 8'h01);
    rd(2'd0, 8'hCD, "R4 ctrl D");

    // R4 TA
    wr(2'd0, 8'h8E);
    evt(2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    chk("R4 TA ignores TAEON", {7'd0, irq}, 8'h00);
    evt(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    chk("R4 TA hit", {7'd0, irq}, 8'h01);
    rd(2'd0, 8'hCF, "R4 ctrl TA");

    // R4 TA-EON
    wr(2'd0, 8'h8A);
    evt(2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    chk("R4 TAEON ignores TA", {7'd0, irq}, 8'h00);
    evt(2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 0);
    chk("R4 TAEON hit", {7'd0, irq}, 8'h01);
    rd(2'd0, 8'hCB, "R4 ctrl TAEON");

    // R4 unused code 100
    wr(2'd0, 8'h88);
    evt(2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 0);
    chk("R4 code 100", {7'd0, irq}, 8'h00);
    rd(2'd0, 8'hC8, "R11 bne only");

    // R7 same source, resync bit
    wr(2'd0, 8'h88);
    chk_pulse("R7 same src", 1'b0);
    wr(2'd0, 8'hA8);
    chk_pulse("R7 resync bit", 1'b1);
    rd(2'd0, 8'h88, "R3 resync reads 0");

    // R6 set beats clear
    wr(2'd0, 8'h82);
    exp_q.push_back(8'h82); tag_q.push_back("R6 collision read");
    @(negedge clk);
    rd_strobe = 1'b1; rd_addr = 2'd0;
    evt_valid = 1'b1; evt_blk = 2'b10; evt_e = 1'b0; evt_synz = 1'b0;
    @(negedge clk);
    rd_strobe = 1'b0; evt_valid = 1'b0;
    chk("R6 set wins", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h04);
    rd(2'd0, 8'hC3, "R2 ctrl kept");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 left", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule